// File: doc/BRIEF.md
# Error-Tolerant Sync Pattern Detector

This block hunts for a programmed sync pattern in a received serial bit stream. Each accepted bit enters a history register. The newest N bits are then compared against the lowest N bits of the programmed pattern, where N is picked from four lengths. A match is declared when the number of differing bits is no larger than a programmed tolerance of zero to three errors. The block then raises a one-cycle detect pulse.

A receiver uses the pulse to mark the start of a packet. In four-level signalling it also uses the pulse to fix which received bit of each symbol pair is the most significant. The pattern is transmitted and compared most significant bit first, so the pattern's bit N-1 is the oldest bit in the window and bit 0 is the newest. Demodulation and clock recovery happen upstream of this block.

Top module: `sync_hunter`

## Requirements
- R1: A synchronous active-high `rst` clears the history, the count of bits received and `sync_hit`. `sync_hit` is low in the cycle after any reset cycle, even if `bit_en` was high in that cycle.
- R2: A bit is taken only in a cycle where `bit_en` is high. A cycle with `bit_en` low changes no state and is followed by a cycle with `sync_hit` low.
- R3: The window length N is 12 + 4·`len_sel`, so codes 0, 1, 2 and 3 select 12, 16, 20 and 24 bits.
- R4: The pattern is compared most significant bit first. After the N-th newest bit, `pattern[N-1]` lines up with the oldest bit in the window and `pattern[0]` with the newest bit. Pattern bits at index N and above have no effect.
- R5: A match needs the count of window positions where received bit and pattern bit differ to be at most `tol_sel`, which is read as an unsigned error count from 0 to 3.
- R6: `sync_hit` is registered. It is high for exactly the one clock cycle that follows the edge which accepted the bit completing a match.
- R7: No match is declared until at least N bits have been accepted since the last reset.
- R8: The match test is repeated on every accepted bit, so overlapping or back-to-back matches each give their own pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies `bit_in` as a new received bit |
| bit_in | input | 1 | Recovered serial data bit |
| pattern | input | 24 | Sync pattern, low N bits used, bit N-1 sent first |
| len_sel | input | 2 | Window length code, N = 12 + 4·code |
| tol_sel | input | 2 | Number of bit errors accepted, 0 to 3 |
| sync_hit | output | 1 | One-cycle pulse after a matching bit |

## Verification
Two events can land in the same cycle: the arrival of a bit that completes a match, and a synchronous reset. The bench provokes this by streaming a pattern that matches on every bit and then raising `rst` together with `bit_en` on a matching bit. It expects `sync_hit` to stay low, because reset wins. A second clash comes from a pattern that is already satisfied by the reset-cleared history. There the N-th bit since reset is also the first bit allowed to fire, and the bench checks that the pulse appears on that bit and on none before it.

// File: rtl/sync_hunter_pkg.sv
package sync_hunter_pkg;
    localparam int DEF_MAX_LEN  = 24;
    localparam int DEF_BASE_LEN = 12;
    localparam int DEF_LEN_STEP = 4;
    localparam int DEF_SEL_W    = 2;
    localparam int DEF_TOL_W    = 2;
endpackage

// File: rtl/sync_hunter_window.sv
// Turns the length code into the window size and a per-bit enable mask.
module sync_hunter_window #(
    parameter int MAX_LEN  = 24,
    parameter int BASE_LEN = 12,
    parameter int LEN_STEP = 4,
    parameter int SEL_W    = 2,
    localparam int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic [SEL_W-1:0]   len_sel,
    output logic [CNT_W-1:0]   need,
    output logic [MAX_LEN-1:0] mask
);
    always_comb begin
        need = CNT_W'(BASE_LEN + LEN_STEP * int'(len_sel));
    end

    for (genvar i = 0; i < MAX_LEN; i++) begin : g_mask
        assign mask[i] = (CNT_W'(i) < need);
    end
endmodule

// File: rtl/sync_hunter_diff.sv
// Counts the positions inside the window where history and pattern differ.
module sync_hunter_diff #(
    parameter int MAX_LEN = 24,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic [MAX_LEN-1:0] hist,
    input  logic [MAX_LEN-1:0] pattern,
    input  logic [MAX_LEN-1:0] mask,
    output logic [CNT_W-1:0]   miss
);
    logic [MAX_LEN-1:0] diff_bits;

    assign diff_bits = (hist ^ pattern) & mask;

    always_comb begin
        miss = '0;
        for (int i = 0; i < MAX_LEN; i++) begin
            miss = miss + CNT_W'(diff_bits[i]);
        end
    end
endmodule

// File: rtl/sync_hunter.sv
module sync_hunter
    import sync_hunter_pkg::*;
#(
    parameter int MAX_LEN  = DEF_MAX_LEN,
    parameter int BASE_LEN = DEF_BASE_LEN,
    parameter int LEN_STEP = DEF_LEN_STEP,
    parameter int SEL_W    = DEF_SEL_W,
    parameter int TOL_W    = DEF_TOL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               bit_in,
    input  logic [MAX_LEN-1:0] pattern,
    input  logic [SEL_W-1:0]   len_sel,
    input  logic [TOL_W-1:0]   tol_sel,
    output logic               sync_hit
);
    localparam int CNT_W = $clog2(MAX_LEN + 1);

    typedef struct packed {
        logic [MAX_LEN-1:0] hist;
        logic [CNT_W-1:0]   fill;
        logic               hit;
    } state_t;

    state_t state_q, state_d;

    logic [MAX_LEN-1:0] hist_shift;
    logic [CNT_W-1:0]   fill_inc;
    logic [CNT_W-1:0]   need;
    logic [MAX_LEN-1:0] mask;
    logic [CNT_W-1:0]   miss;

    // Candidate history and fill count for the bit now offered.
    assign hist_shift = {state_q.hist[MAX_LEN-2:0], bit_in};
    assign fill_inc   = (state_q.fill == CNT_W'(MAX_LEN)) ? state_q.fill
                                                          : state_q.fill + 1'b1;

    sync_hunter_window #(
        .MAX_LEN (MAX_LEN),
        .BASE_LEN(BASE_LEN),
        .LEN_STEP(LEN_STEP),
        .SEL_W   (SEL_W)
    ) u_window (
        .len_sel(len_sel),
        .need   (need),
        .mask   (mask)
    );

    sync_hunter_diff #(
        .MAX_LEN(MAX_LEN)
    ) u_diff (
        .hist   (hist_shift),
        .pattern(pattern),
        .mask   (mask),
        .miss   (miss)
    );

    always_comb begin
        state_d     = state_q;
        state_d.hit = 1'b0;
        if (bit_en) begin
            state_d.hist = hist_shift;
            state_d.fill = fill_inc;
            state_d.hit  = (fill_inc >= need) && (miss <= CNT_W'(tol_sel));
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign sync_hit = state_q.hit;
endmodule

// File: rtl/sync_hunter_chk.sv
module sync_hunter_chk #(
    parameter int MAX_LEN  = 24,
    parameter int BASE_LEN = 12,
    parameter int LEN_STEP = 4,
    parameter int SEL_W    = 2,
    parameter int TOL_W    = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               bit_en,
    input logic               bit_in,
    input logic [MAX_LEN-1:0] pattern,
    input logic [SEL_W-1:0]   len_sel,
    input logic [TOL_W-1:0]   tol_sel,
    input logic               sync_hit
);
    localparam int CNT_W = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0]   seen_q;
    logic [MAX_LEN-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q   <= '0;
            shadow_q <= '0;
        end else if (bit_en) begin
            shadow_q <= {shadow_q[MAX_LEN-2:0], bit_in};
            if (seen_q != CNT_W'(MAX_LEN)) seen_q <= seen_q + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !sync_hit);

    // R2
    hit_follows_bit_chk: assert property (@(posedge clk) disable iff (rst)
        sync_hit |-> $past(bit_en));

    // R7
    fill_guard_chk: assert property (@(posedge clk) disable iff (rst)
        sync_hit |-> (int'(seen_q) >= BASE_LEN + LEN_STEP * int'($past(len_sel))));

    // R5
    exact_full_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_hit && $past(tol_sel) == '0 && $past(len_sel) == '1)
        |-> (shadow_q == $past(pattern)));
endmodule

bind sync_hunter sync_hunter_chk #(
    .MAX_LEN (MAX_LEN),
    .BASE_LEN(BASE_LEN),
    .LEN_STEP(LEN_STEP),
    .SEL_W   (SEL_W),
    .TOL_W   (TOL_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .pattern (pattern),
    .len_sel (len_sel),
    .tol_sel (tol_sel),
    .sync_hit(sync_hit)
);

// File: tb/sync_hunter_test.sv
`timescale 1ns/1ps
module sync_hunter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic [23:0] pattern = '0;
    logic [1:0]  len_sel = '0;
    logic [1:0]  tol_sel = '0;
    logic        sync_hit;

    always #2 clk = ~clk;

    sync_hunter uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .pattern(pattern), .len_sel(len_sel), .tol_sel(tol_sel),
        .sync_hit(sync_hit)
    );

    int          errors = 0;
    int          checks = 0;
    string       tag = "R1";
    logic        exp_hit = 1'b0;
    logic [23:0] m_hist = '0;
    int          m_fill = 0;
    bit          done = 1'b0;
    logic [23:0] nx_pat = '0;
    logic [1:0]  nx_len = '0;
    logic [1:0]  nx_tol = '0;

    function automatic int need_of(logic [1:0] s);
        return 12 + 4 * int'(s);
    endfunction

    function automatic int diffs(logic [23:0] h, logic [23:0] p, int n);
        int c = 0;
        for (int i = 0; i < n; i++) if (h[i] != p[i]) c++;
        return c;
    endfunction

    // Check the result of the previous cycle, then drive the next one.
    task automatic step(input logic r, input logic e, input logic b);
        @(negedge clk);
        checks++;
        if (sync_hit !== exp_hit) begin
            errors++;
            $display("FAIL %s: sync_hit=%0b expected %0b", tag, sync_hit, exp_hit);
        end
        rst = r; bit_en = e; bit_in = b;
        pattern = nx_pat; len_sel = nx_len; tol_sel = nx_tol;
        if (r) begin
            m_hist = '0; m_fill = 0; exp_hit = 1'b0;
        end else if (e) begin
            m_hist = {m_hist[22:0], b};
            if (m_fill < 24) m_fill++;
            exp_hit = (m_fill >= need_of(nx_len)) &&
                      (diffs(m_hist, nx_pat, need_of(nx_len)) <= int'(nx_tol));
        end else begin
            exp_hit = 1'b0;
        end
    endtask

    task automatic send(input logic [23:0] flips, input bit gaps);
        for (int i = need_of(nx_len) - 1; i >= 0; i--) begin
            step(1'b0, 1'b1, nx_pat[i] ^ flips[i]);
            if (gaps) begin step(1'b0, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b1); end
        end
    endtask

    task automatic do_reset();
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run not done, expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state
        tag = "R1";
        step(1'b1, 1'b0, 0); step(1'b1, 1'b0, 0); step(1'b0, 1'b0, 0); step(1'b0, 1'b0, 0);

        // R7 zero pattern matches the cleared history; hit only at bit 12
        tag = "R7"; nx_pat = '0; nx_len = 2'd0; nx_tol = 2'd3;
        do_reset();
        for (int i = 0; i < 13; i++) step(1'b0, 1'b1, 1'b0);
        // R8 back-to-back matches each pulse
        tag = "R8";
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0);
        // R1 reset in the same cycle as a matching bit
        tag = "R1";
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);

        // R3 each length, random prefix then the pattern
        for (int l = 0; l < 4; l++) begin
            tag = "R3"; nx_len = 2'(l); nx_tol = 2'd0; nx_pat = 24'($urandom);
            do_reset();
            for (int i = 0; i < 24; i++) step(1'b0, 1'b1, 1'($urandom));
            send('0, 1'b0);
            tag = "R6";
            step(1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0);
        end

        // R4 bits above the window flipped in the stream have no effect
        tag = "R4"; nx_len = 2'd0; nx_tol = 2'd0; nx_pat = 24'hA5C_3C9;
        do_reset();
        for (int i = 23; i >= 0; i--) step(1'b0, 1'b1, nx_pat[i] ^ (i >= 12));
        step(1'b0, 1'b0, 1'b0);

        // R5 tolerance boundary: tol errors pass, tol+1 errors fail
        for (int t = 0; t < 4; t++) begin
            tag = "R5"; nx_len = 2'd1; nx_tol = 2'(t); nx_pat = 24'($urandom);
            do_reset();
            send(24'((1 << t) - 1) << 3, 1'b0);
            step(1'b0, 1'b0, 1'b0);
            do_reset();
            send(24'((1 << (t + 1)) - 1) << 3, 1'b0);
            step(1'b0, 1'b0, 1'b0);
        end

        // R2 idle cycles between bits change nothing
        tag = "R2"; nx_len = 2'd2; nx_tol = 2'd1; nx_pat = 24'($urandom);
        do_reset();
        send(24'h000010, 1'b1);
        step(1'b0, 1'b0, 1'b0);

        // Random stream with injected noisy patterns
        begin
            int inj = 0;
            for (int c = 0; c < 6000; c++) begin
                logic e, b;
                tag = (c % 2 == 0) ? "R5" : "R8";
                if (inj == 0 && $urandom % 150 == 0) begin
                    nx_len = 2'($urandom); nx_tol = 2'($urandom); nx_pat = 24'($urandom);
                end
                if (inj == 0 && $urandom % 15 == 0) inj = need_of(nx_len);
                e = ($urandom % 4 != 0);
                b = 1'($urandom);
                if (e && inj > 0) begin
                    b = nx_pat[inj - 1] ^ ($urandom % 10 == 0);
                    inj--;
                end
                if ($urandom % 700 == 0) begin tag = "R1"; step(1'b1, e, b); inj = 0; end
                else step(1'b0, e, b);
            end
        end
        step(1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule